// File: doc/BRIEF.md
# Jump and Subroutine-Call Sequencer

This block carries out the unconditional jump and subroutine-call instructions of a small 8-bit accumulator CPU. On a start strobe it takes an opcode byte, up to two operand bytes and the current 8-bit index register. It decodes one of five addressing modes and forms a 16-bit effective address. For a jump it then loads its program counter with that address. For a call it first writes the return address onto a byte-wide stack through a write port, low byte first. The stack pointer counts down after each byte. Only then does it jump.

Each instruction takes a fixed number of cycles that depends on the mode and the kind. The cycle that carries the start strobe counts as the first. A single-cycle done pulse marks the last cycle. The new program counter is visible on that cycle. Operands are captured at the start strobe, so the caller may change them afterwards. An opcode outside the ten supported encodings raises a one-cycle error flag. Program counter and stack pointer keep their values in that case.

Top module: `jmpcall_seq`

## Requirements
- R1: Jump opcodes are 0xBC (8-bit direct address, high byte zero), 0xCC (16-bit address {opHi,opLo}), 0xDC ({opHi,opLo} plus index), 0xEC (opLo plus index) and 0xFC (index alone, high byte zero). The program counter ends at the effective address so formed.
- R2: Call opcodes 0xBD, 0xCD, 0xDD, 0xED and 0xFD use the same five addressing modes, in the same order, and end with the program counter at the effective address.
- R3: Counting the start cycle as cycle 1, a jump takes 2, 3, 4, 3 or 2 cycles for the direct, 16-bit, index+16-bit, index+8-bit and index-only modes. `done` is high on exactly the last cycle and low on the cycle after it.
- R4: Calls take 5, 6, 7, 6 or 5 cycles for the same mode order. `done` is high on exactly the last cycle.
- R5: The pushed return address is the program counter at start plus the instruction length: 2 for direct, 3 for 16-bit, 3 for index+16-bit, 2 for index+8-bit and 1 for index-only. The sum wraps modulo 2^16.
- R6: A call writes the low return byte at address SP in cycle 2. It writes the high byte at SP-1 in cycle 3. It ends with SP reduced by 2. Stack writes occur at no other time.
- R7: `pcOut` keeps its old value until the last cycle, and it shows the new value from the last cycle on.
- R8: The effective-address sums wrap modulo 2^16.
- R9: A start with an undefined opcode sets `err` for exactly the next cycle. It produces no `done` and no stack write, and it leaves PC and SP unchanged.
- R10: A start strobe while an instruction is in progress is ignored: the running instruction completes unchanged and no error is raised.
- R11: After reset `pcOut` equals `PC_RESET`, SP equals `SP_RESET` (0xFF by default), and `done`, `err` and `stkWe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction this cycle |
| opcode | input | 8 | Instruction opcode, sampled at start |
| opHi | input | 8 | First operand byte (high address/offset byte) |
| opLo | input | 8 | Last operand byte (low address/offset byte) |
| idxReg | input | 8 | Index register value, sampled at start |
| stkWe | output | 1 | Stack write enable |
| stkAddr | output | 8 | Stack write address (current SP) |
| stkData | output | 8 | Stack write data |
| pcOut | output | 16 | Program counter |
| done | output | 1 | High on the final cycle of an instruction |
| err | output | 1 | One-cycle undefined-opcode flag |

## Verification
All ten opcodes are run once each. The operand bytes are chosen so that each mode gives a different address, which catches a swapped mode decode or a dropped index addition. The operands are also scrambled right after start, which separates latched operands from live ones. Calls are issued from program counters whose low bytes differ per mode, so the pushed bytes show both the per-mode length and a swapped push order. Wrapping sums, undefined opcodes and a strobe in the middle of an instruction each check a boundary: the carry out of bit 15, the error path leaving PC and SP alone, and the busy guard.

// File: rtl/jmpcall_pkg.sv
package jmpcall_pkg;

  typedef enum logic [2:0] {
    M_DIR = 3'd0,
    M_EXT = 3'd1,
    M_IX2 = 3'd2,
    M_IX1 = 3'd3,
    M_IX  = 3'd4
  } addrMode_e;

  typedef struct packed {
    logic      valid;
    logic      isCall;
    addrMode_e mode;
    logic [1:0] len;
    logic [2:0] cycles;
  } decode_t;

  typedef struct packed {
    logic capture;
    logic pcLoad;
    logic push;
    logic pushHigh;
  } strobe_t;

  function automatic decode_t decodeOp(input logic [7:0] op);
    decode_t d;
    d.valid  = 1'b1;
    d.isCall = (op[3:0] == 4'hD);
    d.mode   = M_DIR;
    d.len    = 2'd2;
    d.cycles = 3'd2;
    if (op[3:0] != 4'hC && op[3:0] != 4'hD) d.valid = 1'b0;
    case (op[7:4])
      4'hB: begin d.mode = M_DIR; d.len = 2'd2; d.cycles = 3'd2; end
      4'hC: begin d.mode = M_EXT; d.len = 2'd3; d.cycles = 3'd3; end
      4'hD: begin d.mode = M_IX2; d.len = 2'd3; d.cycles = 3'd4; end
      4'hE: begin d.mode = M_IX1; d.len = 2'd2; d.cycles = 3'd3; end
      4'hF: begin d.mode = M_IX;  d.len = 2'd1; d.cycles = 3'd2; end
      default: d.valid = 1'b0;
    endcase
    if (d.isCall) d.cycles = d.cycles + 3'd3;
    return d;
  endfunction

endpackage

// File: rtl/jmpcall_ctrl.sv
module jmpcall_ctrl
  import jmpcall_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  decode_t dec,
  output strobe_t str,
  output logic    stkWe,
  output logic    done,
  output logic    err
);

  localparam int CNT_W = 3;

  logic             busy;
  logic             isCallQ;
  logic [CNT_W-1:0] cyc;
  logic [CNT_W-1:0] total;
  logic             errQ;
  logic             accept;
  logic             lastCyc;
  logic             preLast;

  assign accept  = !busy && start && dec.valid;
  assign lastCyc = busy && (cyc == total);
  assign preLast = busy && (CNT_W'(cyc + 1'b1) == total);

  always_comb begin
    str          = '0;
    str.capture  = accept;
    str.pcLoad   = (accept && dec.cycles == CNT_W'(2)) || preLast;
    str.push     = busy && isCallQ && (cyc == CNT_W'(2) || cyc == CNT_W'(3));
    str.pushHigh = (cyc == CNT_W'(3));
  end

  assign stkWe = str.push;
  assign done  = lastCyc;
  assign err   = errQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      isCallQ <= 1'b0;
      cyc     <= '0;
      total   <= '0;
      errQ    <= 1'b0;
    end else begin
      errQ <= !busy && start && !dec.valid;
      if (accept) begin
        busy    <= 1'b1;
        isCallQ <= dec.isCall;
        cyc     <= CNT_W'(2);
        total   <= dec.cycles;
      end else if (busy) begin
        if (lastCyc) begin
          busy <= 1'b0;
          cyc  <= '0;
        end else begin
          cyc <= cyc + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/jmpcall_dp.sv
module jmpcall_dp
  import jmpcall_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SP_W = 8,
  parameter logic [2*BYTE_W-1:0] PC_RESET = '0,
  parameter logic [SP_W-1:0] SP_RESET = '1
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             str,
  input  decode_t             dec,
  input  logic [BYTE_W-1:0]   opHi,
  input  logic [BYTE_W-1:0]   opLo,
  input  logic [BYTE_W-1:0]   idxReg,
  output logic [SP_W-1:0]     stkAddr,
  output logic [BYTE_W-1:0]   stkData,
  output logic [2*BYTE_W-1:0] pcOut
);

  localparam int ADDR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] eaNext;
  logic [ADDR_W-1:0] eaQ;
  logic [ADDR_W-1:0] retQ;
  logic [ADDR_W-1:0] pcQ;
  logic [SP_W-1:0]   spQ;
  logic [ADDR_W-1:0] wideOp;
  logic [ADDR_W-1:0] wideIdx;
  logic [ADDR_W-1:0] wideLo;

  assign wideOp  = {opHi, opLo};
  assign wideIdx = {{BYTE_W{1'b0}}, idxReg};
  assign wideLo  = {{BYTE_W{1'b0}}, opLo};

  always_comb begin
    case (dec.mode)
      M_DIR:   eaNext = wideLo;
      M_EXT:   eaNext = wideOp;
      M_IX2:   eaNext = wideOp + wideIdx;
      M_IX1:   eaNext = wideLo + wideIdx;
      default: eaNext = wideIdx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      eaQ  <= '0;
      retQ <= '0;
      pcQ  <= PC_RESET;
      spQ  <= SP_RESET;
    end else begin
      if (str.capture) begin
        eaQ  <= eaNext;
        retQ <= pcQ + ADDR_W'(dec.len);
      end
      if (str.pcLoad) pcQ <= str.capture ? eaNext : eaQ;
      if (str.push) spQ <= spQ - 1'b1;
    end
  end

  assign stkAddr = spQ;
  assign stkData = str.pushHigh ? retQ[ADDR_W-1:BYTE_W] : retQ[BYTE_W-1:0];
  assign pcOut   = pcQ;

endmodule

// File: rtl/jmpcall_seq.sv
module jmpcall_seq
  import jmpcall_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SP_W = 8,
  parameter logic [2*BYTE_W-1:0] PC_RESET = 16'h0300,
  parameter logic [SP_W-1:0] SP_RESET = 8'hFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [7:0]          opcode,
  input  logic [BYTE_W-1:0]   opHi,
  input  logic [BYTE_W-1:0]   opLo,
  input  logic [BYTE_W-1:0]   idxReg,
  output logic                stkWe,
  output logic [SP_W-1:0]     stkAddr,
  output logic [BYTE_W-1:0]   stkData,
  output logic [2*BYTE_W-1:0] pcOut,
  output logic                done,
  output logic                err
);

  decode_t dec;
  strobe_t str;

  assign dec = decodeOp(opcode);

  jmpcall_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .dec   (dec),
    .str   (str),
    .stkWe (stkWe),
    .done  (done),
    .err   (err)
  );

  jmpcall_dp #(
    .BYTE_W   (BYTE_W),
    .SP_W     (SP_W),
    .PC_RESET (PC_RESET),
    .SP_RESET (SP_RESET)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .str     (str),
    .dec     (dec),
    .opHi    (opHi),
    .opLo    (opLo),
    .idxReg  (idxReg),
    .stkAddr (stkAddr),
    .stkData (stkData),
    .pcOut   (pcOut)
  );

endmodule

// File: rtl/jmpcall_seq_chk.sv
module jmpcall_seq_chk #(
  parameter int SP_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic              err,
  input logic              stkWe,
  input logic [SP_W-1:0]   stkAddr,
  input logic [ADDR_W-1:0] pcOut
);

  // R3/R4: done is a single-cycle pulse
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: second push goes one below the first
  a_r6_push_descends: assert property (@(posedge clk) disable iff (!rstN)
    (stkWe && $past(stkWe)) |-> (stkAddr == $past(stkAddr) - 1'b1));

  // R6: no stack write on the final cycle
  a_r6_no_push_at_done: assert property (@(posedge clk) disable iff (!rstN)
    stkWe |-> !done);

  // R7: PC only moves into the final cycle
  a_r7_pc_moves_at_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(pcOut) |-> done);

  // R9: error cycle has no completion and no write
  a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!done && !stkWe));

  // R9: PC holds across an error
  a_r9_err_pc_hold: assert property (@(posedge clk) disable iff (!rstN)
    err |-> $stable(pcOut));

endmodule

bind jmpcall_seq jmpcall_seq_chk #(.SP_W(SP_W), .ADDR_W(2*BYTE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .err     (err),
  .stkWe   (stkWe),
  .stkAddr (stkAddr),
  .pcOut   (pcOut)
);

// File: tb/tb_jmpcall_seq.sv
module tb_jmpcall_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [7:0]  opHi = 8'h00;
  logic [7:0]  opLo = 8'h00;
  logic [7:0]  idxReg = 8'h00;
  logic        stkWe;
  logic [7:0]  stkAddr;
  logic [7:0]  stkData;
  logic [15:0] pcOut;
  logic        done;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] expPc = 16'h0300;
  logic [7:0]  expSp = 8'hFF;

  always #2.5 clk = ~clk;

  jmpcall_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode), .opHi(opHi),
    .opLo(opLo), .idxReg(idxReg), .stkWe(stkWe), .stkAddr(stkAddr),
    .stkData(stkData), .pcOut(pcOut), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Runs one jump/call; optionally strobes start again in cycle 3.
  task automatic runInstr(input logic [7:0] op, input logic [7:0] hi,
                          input logic [7:0] lo, input logic [7:0] x,
                          input bit poke);
    int mode = int'(op[7:4]) - 11;
    bit isCall = (op[3:0] == 4'hD);
    int len;
    int n;
    logic [15:0] ea;
    logic [15:0] ret;
    logic [15:0] oldPc = expPc;
    case (mode)
      0: begin len = 2; n = 2; ea = {8'h00, lo}; end
      1: begin len = 3; n = 3; ea = {hi, lo}; end
      2: begin len = 3; n = 4; ea = {hi, lo} + {8'h00, x}; end
      3: begin len = 2; n = 3; ea = {8'h00, lo} + {8'h00, x}; end
      default: begin len = 1; n = 2; ea = {8'h00, x}; end
    endcase
    if (isCall) n += 3;
    ret = oldPc + 16'(len);
    @(negedge clk);
    start = 1'b1; opcode = op; opHi = hi; opLo = lo; idxReg = x;
    @(negedge clk);
    start = 1'b0; opHi = ~hi; opLo = ~lo; idxReg = ~x;
    for (int c = 2; c <= n; c++) begin
      bit expWe = isCall && (c == 2 || c == 3);
      check(done == (c == n), isCall ? "R4 done timing" : "R3 done timing",
            32'(done), 32'(c == n));
      check(stkWe == expWe, "R6 write enable", 32'(stkWe), 32'(expWe));
      if (expWe) begin
        check(stkAddr == ((c == 2) ? expSp : expSp - 8'd1), "R6 push address",
              32'(stkAddr), 32'((c == 2) ? expSp : expSp - 8'd1));
        check(stkData == ((c == 2) ? ret[7:0] : ret[15:8]), "R5 return byte",
              32'(stkData), 32'((c == 2) ? ret[7:0] : ret[15:8]));
      end
      check(pcOut == ((c == n) ? ea : oldPc),
            (c == n) ? (isCall ? "R2 target" : "R1 target") : "R7 pc hold",
            32'(pcOut), 32'((c == n) ? ea : oldPc));
      check(err == 1'b0, "R10 no error", 32'(err), 32'd0);
      if (poke && c == 3) begin
        start = 1'b1; opcode = 8'hFC; idxReg = 8'h77;
      end
      @(negedge clk);
      start = 1'b0;
    end
    check(done == 1'b0, "R3 done clears", 32'(done), 32'd0);
    check(pcOut == ea, "R7 pc kept", 32'(pcOut), 32'(ea));
    expPc = ea;
    if (isCall) expSp = expSp - 8'd2;
  endtask

  task automatic badOp(input logic [7:0] op);
    @(negedge clk);
    start = 1'b1; opcode = op;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, "R9 err raised", 32'(err), 32'd1);
    check(done == 1'b0 && stkWe == 1'b0, "R9 quiet", 32'({done, stkWe}), 32'd0);
    check(pcOut == expPc, "R9 pc unchanged", 32'(pcOut), 32'(expPc));
    @(negedge clk);
    check(err == 1'b0, "R9 err one cycle", 32'(err), 32'd0);
  endtask

  task automatic testReset();
    check(pcOut == 16'h0300, "R11 pc reset", 32'(pcOut), 32'h0300);
    check(!done && !err && !stkWe, "R11 idle outputs", 32'({done, err, stkWe}), 32'd0);
  endtask

  task automatic testJumps();
    runInstr(8'hBC, 8'h11, 8'h42, 8'h05, 0);
    runInstr(8'hCC, 8'h12, 8'h34, 8'h05, 0);
    runInstr(8'hDC, 8'h20, 8'h10, 8'h33, 0);
    runInstr(8'hEC, 8'h99, 8'hF0, 8'h20, 0);
    runInstr(8'hFC, 8'h99, 8'h98, 8'h5A, 0);
  endtask

  task automatic testCalls();
    runInstr(8'hCC, 8'h40, 8'hFE, 8'h00, 0);
    runInstr(8'hBD, 8'h00, 8'h80, 8'h00, 0);
    runInstr(8'hCD, 8'h45, 8'h67, 8'h00, 0);
    runInstr(8'hDD, 8'h50, 8'h00, 8'h0F, 0);
    runInstr(8'hED, 8'h00, 8'hC3, 8'h44, 0);
    runInstr(8'hFD, 8'h00, 8'h00, 8'hE1, 0);
  endtask

  task automatic testWrap();
    runInstr(8'hDC, 8'hFF, 8'hF0, 8'h20, 0);   // R8: 0xFFF0 + 0x20 -> 0x0010
    runInstr(8'hCC, 8'hFF, 8'hFF, 8'h00, 0);
    runInstr(8'hCD, 8'h01, 8'h00, 8'h00, 0);   // R5: 0xFFFF + 3 -> 0x0002
  endtask

  task automatic testBad();
    logic [7:0] spBefore = expSp;
    badOp(8'h9D);
    badOp(8'hBE);
    runInstr(8'hFD, 8'h00, 8'h00, 8'h10, 0);   // R9: SP unchanged shows here
    check(expSp == spBefore - 8'd2, "R9 sp model", 32'(expSp), 32'(spBefore - 8'd2));
  endtask

  task automatic testBusy();
    runInstr(8'hDD, 8'h22, 8'h00, 8'h01, 1);   // R10: strobe in cycle 3 ignored
    runInstr(8'hDC, 8'h30, 8'h00, 8'h02, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testJumps();
    testCalls();
    testWrap();
    testBad();
    testBusy();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule